// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder with Blanking Controls

This block turns a four-bit BCD digit into the seven segment drives of one display digit. The segment drives are active low. Three active-low controls sit on top of the plain decoding. A lamp test lights every segment. A leading-zero suppression input hides a zero and reports that it did so on a ripple output, so one digit can pass the suppression on to the next. A blank input turns the digit fully dark.

All paths are combinational, with no clock. To blank leading zeros across a row of digits, connect each digit's ripple output to the ripple input of the next less significant digit. Tie the ripple input high on any digit that must always show a zero. The blank input can be toggled periodically to dim the display.

Top module: `segDecoderTop`

## Requirements
- R1: `segN` bit 0 drives segment a, and the bits run in order up to bit 6, which drives segment g. A lit segment is driven 0. With all controls high, digit 8 drives `segN` to 7'b0000000.
- R2: With `blankInN`, `lampTestN` and `rippleInN` all high, the digits light these segments: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R3: With no lamp test active, the input codes 10 to 15 leave every segment dark (`segN` = 7'b1111111).
- R4: With `blankInN` high and `lampTestN` low, every segment is lit (`segN` = 0), whatever the data and ripple inputs are.
- R5: With `rippleInN` low, `lampTestN` high and `bcdIn` = 0, every segment is dark and `rippleOutN` is 0.
- R6: With `rippleInN` low and a nonzero `bcdIn`, the digit decodes as it would without suppression, and `rippleOutN` stays 1.
- R7: With `blankInN` low, every segment is dark, whatever the data, lamp-test and ripple inputs are. This blanking also overrides the lamp test.
- R8: `rippleOutN` is 0 only when `rippleInN` is 0, `lampTestN` is 1 and `bcdIn` is 0. The blank input has no effect on `rippleOutN`.
- R9: The outputs follow an input change within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcdIn | input | 4 | BCD digit to display |
| lampTestN | input | 1 | Active-low lamp test |
| rippleInN | input | 1 | Active-low zero-suppression request |
| blankInN | input | 1 | Active-low forced blank |
| segN | output | 7 | Active-low segments, bit 0 is a and bit 6 is g |
| rippleOutN | output | 1 | Active-low report that a zero was suppressed |

## Verification
The bench builds the block with its default parameters: a four-bit digit and seven segments. With only seven input bits, every combination of data and controls can be applied, one per clock period. This covers every priority interaction between blank, lamp test and ripple suppression, as well as all six unused codes.

// File: rtl/segDecoderPkg.sv
package segDecoderPkg;
  localparam int SEG_N = 7;

  // control strobes sent to the datapath
  typedef struct packed {
    logic blankAll;
    logic lightAll;
  } segCtrl_t;

  // active-high segment pattern, bit0 = a ... bit6 = g; zero for non-decimal codes
  function automatic logic [SEG_N-1:0] digitPattern(input logic [3:0] d);
    logic [SEG_N-1:0] p;
    case (d)
      4'd0: p = 7'b0111111;
      4'd1: p = 7'b0000110;
      4'd2: p = 7'b1011011;
      4'd3: p = 7'b1001111;
      4'd4: p = 7'b1100110;
      4'd5: p = 7'b1101101;
      4'd6: p = 7'b1111101;
      4'd7: p = 7'b0000111;
      4'd8: p = 7'b1111111;
      4'd9: p = 7'b1101111;
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/segDecoderCtrl.sv
module segDecoderCtrl
  import segDecoderPkg::*;
(
  input  logic     lampTestN,
  input  logic     rippleInN,
  input  logic     blankInN,
  input  logic     isZero,
  output segCtrl_t ctrl,
  output logic     rippleOutN
);
  logic suppressZero;

  always_comb begin
    suppressZero  = !rippleInN && lampTestN && isZero;
    rippleOutN    = !suppressZero;
    ctrl.blankAll = !blankInN || suppressZero;
    ctrl.lightAll = blankInN && !lampTestN;
  end

  always_comb begin
    // R8
    rbo_blank_chk: assert (rippleOutN || (ctrl.blankAll && !ctrl.lightAll))
      else $error("ripple output low without blanking");
    // R7
    bi_priority_chk: assert (blankInN || !ctrl.lightAll)
      else $error("lamp test beat blank input");
  end
endmodule

// File: rtl/segDecoderPath.sv
module segDecoderPath
  import segDecoderPkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] bcdIn,
  input  segCtrl_t           ctrl,
  output logic [SEG_N-1:0]   segN,
  output logic               isZero
);
  localparam int MAX_DIGIT = 9;

  logic [SEG_N-1:0] pattern;
  logic             validDigit;

  always_comb begin
    validDigit = (int'(bcdIn) <= MAX_DIGIT);
    pattern    = digitPattern(4'(bcdIn));
    isZero     = (bcdIn == '0);
  end

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    always_comb begin
      if (ctrl.blankAll)      segN[i] = 1'b1;
      else if (ctrl.lightAll) segN[i] = 1'b0;
      else                    segN[i] = !(validDigit && pattern[i]);
    end
  end

  always_comb begin
    // R7
    blank_off_chk: assert (!ctrl.blankAll || segN == '1)
      else $error("blank strobe left a segment lit");
    // R4
    light_on_chk: assert (ctrl.blankAll || !ctrl.lightAll || segN == '0)
      else $error("lamp test left a segment dark");
    // R3
    invalid_off_chk: assert (ctrl.lightAll || validDigit || segN == '1)
      else $error("unused code lit a segment");
  end
endmodule

// File: rtl/segDecoderTop.sv
module segDecoderTop
  import segDecoderPkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] bcdIn,
  input  logic               lampTestN,
  input  logic               rippleInN,
  input  logic               blankInN,
  output logic [SEG_N-1:0]   segN,
  output logic               rippleOutN
);
  segCtrl_t ctrl;
  logic     isZero;

  segDecoderCtrl ctrl_i (
    .lampTestN (lampTestN),
    .rippleInN (rippleInN),
    .blankInN  (blankInN),
    .isZero    (isZero),
    .ctrl      (ctrl),
    .rippleOutN(rippleOutN)
  );

  segDecoderPath #(.DIGIT_W(DIGIT_W)) path_i (
    .bcdIn (bcdIn),
    .ctrl  (ctrl),
    .segN  (segN),
    .isZero(isZero)
  );
endmodule

// File: tb/segDecoderTop_tb.sv
module segDecoderTop_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic [3:0] bcdIn = 0;
  logic       lampTestN = 1, rippleInN = 1, blankInN = 1;
  logic [6:0] segN;
  logic       rippleOutN;
  int         checks = 0, errors = 0;
  bit         done = 0;

  string litSegs [10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                          "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};

  always #(CLK_PERIOD/2) clk = ~clk;

  segDecoderTop dut_i (
    .bcdIn(bcdIn), .lampTestN(lampTestN), .rippleInN(rippleInN),
    .blankInN(blankInN), .segN(segN), .rippleOutN(rippleOutN)
  );

  function automatic logic [6:0] litMask(int d);
    logic [6:0] m = 0;
    if (d > 9) return 0;
    foreach (litSegs[d][k]) m[litSegs[d][k] - "a"] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [6:0] expSeg, logic expRbo);
    checks++;
    if (segN !== expSeg || rippleOutN !== expRbo) begin
      errors++;
      $display("FAIL %s in=%0d lt=%b rbi=%b bi=%b seg=%b/rbo=%b exp %b/%b",
               req, bcdIn, lampTestN, rippleInN, blankInN,
               segN, rippleOutN, expSeg, expRbo);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 0;
    #1 check("R2 reset", ~litMask(0), 1'b1);
    for (int v = 0; v < 128; v++) begin
      logic [6:0] expSeg;
      logic       expRbo;
      string      req;
      @(negedge clk);
      {blankInN, rippleInN, lampTestN, bcdIn} = 7'(v);
      expRbo = !(rippleInN == 0 && lampTestN == 1 && bcdIn == 0);
      if (!blankInN)                   begin expSeg = 7'h7F; req = "R7"; end
      else if (!lampTestN)             begin expSeg = 7'h00; req = "R4"; end
      else if (!expRbo)                begin expSeg = 7'h7F; req = "R5"; end
      else if (bcdIn > 9)              begin expSeg = 7'h7F; req = "R3"; end
      else if (!rippleInN)             begin expSeg = ~litMask(bcdIn); req = "R6"; end
      else if (bcdIn == 8)             begin expSeg = ~litMask(8); req = "R1"; end
      else                             begin expSeg = ~litMask(bcdIn); req = "R2"; end
      #1 check(req, expSeg, expRbo);
      if (!blankInN) check("R8", expSeg, expRbo);
    end
    // R9: change inputs mid-cycle, outputs must follow before any edge
    @(posedge clk);
    #1 {blankInN, rippleInN, lampTestN, bcdIn} = {3'b111, 4'd7};
    #1 check("R9", ~litMask(7), 1'b1);
    bcdIn = 4'd0; rippleInN = 0;
    #1 check("R9", 7'h7F, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule